// File: doc/BRIEF.md
# Page Write Collector with Timed Programming

This block gathers the data bytes of a serial memory write command into a 64-byte page buffer and then commits them to the storage array during a self-timed programming period. A command decoder upstream tells it when a write command begins, which address it names, and when each complete data byte arrives. It also reports when chip select is released and whether that release falls on a byte boundary. A protection unit supplies the write-enable latch state and answers, for each address, whether that address is currently protected.

During loading, the low six address bits advance after every byte and the upper address bits stay fixed, so a long burst wraps inside its page. When chip select is released cleanly, the block holds a busy flag for a fixed number of clock cycles. Early in that window it walks the page once and issues one array write for every offset that received a byte and is not protected. When the window ends it pulses a request that clears the write-enable latch. Any command activity that arrives during the busy window is ignored.

Top module: `page_write_engine`

## Requirements
- R1: After reset `busy_o`, `wel_clr_o` and `arr_we_o` are all 0.
- R2: A write command that is accepted (`wel_i`=1 when `wr_start_i` is seen) stores each data byte at the page address {upper bits of `wr_addr_i`, offset}. The offset starts at the low 6 bits of `wr_addr_i` and increments by one after each byte. The upper bits never change.
- R3: A byte received after offset 63 goes to offset 0 of the same page and replaces any byte buffered there. Only the last value written to an offset is programmed.
- R4: Programming starts only when `cs_rise_i` arrives with `bit_aligned_i`=1 and at least one byte buffered. In any other case the command is dropped, with no busy period and no array write.
- R5: A write command seen while `wel_i`=0 is discarded. Its bytes are never programmed.
- R6: Only offsets that received a byte are written to the array. Other addresses of the page are left untouched.
- R7: A buffered byte whose address makes `chk_prot_i`=1 during the commit walk is not written.
- R8: `busy_o` rises in the cycle after the accepted `cs_rise_i` and stays high for exactly `TWC_CYCLES` cycles.
- R9: `wel_clr_o` is a single-cycle pulse in the cycle right after `busy_o` falls. It occurs only at the end of a programming period.
- R10: `wr_start_i`, `byte_vld_i` and `cs_rise_i` are ignored while `busy_o`=1. The running programming completes unchanged.
- R11: `arr_we_o` is asserted only while `busy_o`=1. The commit walk visits offsets in ascending order, one per cycle, starting with the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_start_i | input | 1 | Pulse: write command decoded, address valid |
| wr_addr_i | input | ADDR_W | Start address of the write command |
| wel_i | input | 1 | Write-enable latch state from the protection unit |
| byte_vld_i | input | 1 | Pulse: a complete data byte is on `byte_i` |
| byte_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | Pulse: chip select released |
| bit_aligned_i | input | 1 | Chip select release fell on a byte boundary |
| chk_addr_o | output | ADDR_W | Address presented to the protection unit |
| chk_prot_i | input | 1 | `chk_addr_o` is inside the protected range |
| busy_o | output | 1 | Programming in progress |
| wel_clr_o | output | 1 | Pulse: clear the write-enable latch |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
Several internal faults show up as wrong data in the bench's model of the array. A wrong offset counter or a wrong wrap puts bytes at the wrong address. A stale valid mask writes neighbours that were never loaded. These are visible as soon as the commit walk ends, within 64 cycles of the busy flag rising. A faulty programming timer or state machine changes how long `busy_o` stays high, or moves or drops the `wel_clr_o` pulse. Both are measured to the exact cycle. A leak of command activity into the busy window shows up either as a second busy period or as data from a foreign page.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgw_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PAGE_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              any_o
);
  localparam int unsigned DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  mask_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else if (we_i)  mask_q[waddr_i] <= 1'b1;
  end

  assign rdata_o  = mem_q[raddr_i];
  assign rvalid_o = mask_q[raddr_i];
  assign any_o    = |mask_q;

  // a fresh command must start from an empty mask
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !any_o) else $error("mask not cleared"); // R6
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int unsigned TWC_CYCLES = 250000,
  localparam int unsigned CW = $clog2(TWC_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST = CW'(TWC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (start_i)  cnt_q <= '0;
    else if (run_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign done_o = run_i && (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= LAST) else $error("timer overrun"); // R8
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import pgw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned PAGE_W     = 6,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TWC_CYCLES = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wel_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              cs_rise_i,
  input  logic              bit_aligned_i,
  output logic [ADDR_W-1:0] chk_addr_o,
  input  logic              chk_prot_i,
  output logic              busy_o,
  output logic              wel_clr_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  localparam int unsigned PAGE = 1 << PAGE_W;
  localparam int unsigned HI_W = ADDR_W - PAGE_W;
  localparam int unsigned CW   = $clog2(TWC_CYCLES + 1);

  pgw_state_e        state_q, state_d;
  logic [HI_W-1:0]   page_q;
  logic [PAGE_W-1:0] off_q;
  logic              clr_q;

  logic              accept, buf_we, buf_clr, buf_any, buf_rvalid;
  logic [DATA_W-1:0] buf_rdata;
  logic              tmr_start, tmr_done;
  logic [CW-1:0]     tmr_cnt;
  logic              walk_act;
  logic [PAGE_W-1:0] walk_off;

  assign accept  = (state_q == ST_IDLE) && wr_start_i && wel_i;
  assign buf_clr = accept;
  assign buf_we  = (state_q == ST_LOAD) && byte_vld_i;

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOAD;
      ST_LOAD: if (cs_rise_i) begin
        if (bit_aligned_i && buf_any) begin
          state_d   = ST_PROG;
          tmr_start = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_PROG: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= (state_q == ST_PROG) && tmr_done;
      if (accept) begin
        page_q <= wr_addr_i[ADDR_W-1:PAGE_W];
        off_q  <= wr_addr_i[PAGE_W-1:0];
      end else if (buf_we) begin
        off_q  <= off_q + 1'b1; // wraps inside the page
      end
    end
  end

  pgw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (buf_clr),
    .we_i    (buf_we),
    .waddr_i (off_q),
    .wdata_i (byte_i),
    .raddr_i (walk_off),
    .rdata_o (buf_rdata),
    .rvalid_o(buf_rvalid),
    .any_o   (buf_any)
  );

  pgw_timer #(.TWC_CYCLES(TWC_CYCLES)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .run_i  (state_q == ST_PROG),
    .cnt_o  (tmr_cnt),
    .done_o (tmr_done)
  );

  // commit walk uses the first PAGE cycles of the timed window
  assign walk_off = tmr_cnt[PAGE_W-1:0];
  assign walk_act = (state_q == ST_PROG) && (tmr_cnt < CW'(PAGE));

  assign chk_addr_o = {page_q, walk_off};
  assign arr_addr_o = {page_q, walk_off};
  assign arr_data_o = buf_rdata;
  assign arr_we_o   = walk_act && buf_rvalid && !chk_prot_i;
  assign busy_o     = (state_q == ST_PROG);
  assign wel_clr_o  = clr_q;

  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o) else $error("write outside busy"); // R11
  AST_CLR_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> wel_clr_o) else $error("no latch clear"); // R9
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !wel_clr_o) else $error("clear pulse too long"); // R9
  AST_ABORT_UNALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) && cs_rise_i && !bit_aligned_i |=> !busy_o)
    else $error("unaligned release started programming"); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tmr_done |=> busy_o) else $error("busy dropped early"); // R8
  AST_PAGE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(page_q)) else $error("page changed while busy"); // R10
endmodule

// File: tb/page_write_engine_test.sv
module page_write_engine_test;
  localparam int unsigned AW  = 11;
  localparam int unsigned TWC = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_start = 1'b0, wel = 1'b0, byte_vld = 1'b0;
  logic          cs_rise = 1'b0, aligned = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    byte_d = '0;
  logic [AW-1:0] chk_addr, arr_addr;
  logic          chk_prot, busy, wel_clr, arr_we;
  logic [7:0]    arr_data;
  logic [11:0]   prot_lo = 12'h800;

  logic [7:0] amem [1 << AW];
  int n_tests = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  assign chk_prot = ({1'b0, chk_addr} >= prot_lo);

  page_write_engine #(.ADDR_W(AW), .TWC_CYCLES(TWC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_start_i(wr_start), .wr_addr_i(wr_addr),
    .wel_i(wel), .byte_vld_i(byte_vld), .byte_i(byte_d), .cs_rise_i(cs_rise),
    .bit_aligned_i(aligned), .chk_addr_o(chk_addr), .chk_prot_i(chk_prot),
    .busy_o(busy), .wel_clr_o(wel_clr), .arr_we_o(arr_we),
    .arr_addr_o(arr_addr), .arr_data_o(arr_data));

  always @(posedge clk) if (arr_we) amem[arr_addr] <= arr_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        report();
      end
    end
  end

  task automatic start_cmd(input logic [AW-1:0] a, input logic en);
    @(negedge clk); wr_start = 1'b1; wr_addr = a; wel = en;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_d = d;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic cs_up(input logic al);
    @(negedge clk); cs_rise = 1'b1; aligned = al;
    @(negedge clk); cs_rise = 1'b0; aligned = 1'b0;
  endtask

  // counts busy cycles from here, then checks the latch-clear pulse
  task automatic wait_prog(input int exp_busy, input string tag);
    int n = 0;
    int clr_seen = 0;
    while (busy && n < TWC + 20) begin
      if (wel_clr) clr_seen++;
      n++;
      @(negedge clk);
    end
    chk(n == exp_busy, {tag, " R8 busy length"}, n, exp_busy);
    chk(wel_clr == (exp_busy != 0), {tag, " R9 clear pulse"}, wel_clr, exp_busy != 0);
    @(negedge clk);
    chk(!wel_clr && clr_seen == 0, {tag, " R9 single pulse"}, wel_clr, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !wel_clr && !arr_we, "R1 reset outputs", {busy, wel_clr, arr_we}, 0);
  endtask

  task automatic t_basic();
    start_cmd(11'h105, 1'b1);
    send_byte(8'h31); send_byte(8'h32); send_byte(8'h33);
    cs_up(1'b1);
    wait_prog(TWC, "basic");
    chk(amem[11'h105] == 8'h31, "R2 first byte", amem[11'h105], 8'h31);
    chk(amem[11'h107] == 8'h33, "R2 third byte", amem[11'h107], 8'h33);
    chk(amem[11'h104] == 8'hEE, "R6 below untouched", amem[11'h104], 8'hEE);
    chk(amem[11'h108] == 8'hEE, "R6 above untouched", amem[11'h108], 8'hEE);
  endtask

  task automatic t_wrap();
    start_cmd(11'h0BE, 1'b1);
    for (int k = 1; k <= 4; k++) send_byte(8'(k));
    cs_up(1'b1);
    wait_prog(TWC, "wrap");
    chk(amem[11'h0BF] == 8'h02, "R2 last offset", amem[11'h0BF], 8'h02);
    chk(amem[11'h080] == 8'h03, "R3 wrap to page start", amem[11'h080], 8'h03);
    chk(amem[11'h0C0] == 8'hEE, "R2 upper bits fixed", amem[11'h0C0], 8'hEE);
  endtask

  task automatic t_overwrite();
    start_cmd(11'h300, 1'b1);
    for (int k = 0; k <= 64; k++) send_byte(8'(k + 16));
    cs_up(1'b1);
    wait_prog(TWC, "overwrite");
    chk(amem[11'h300] == 8'h50, "R3 overwrite offset 0", amem[11'h300], 8'h50);
    chk(amem[11'h33F] == 8'h4F, "R3 offset 63", amem[11'h33F], 8'h4F);
    chk(amem[11'h340] == 8'hEE, "R3 next page untouched", amem[11'h340], 8'hEE);
  endtask

  task automatic t_aborts();
    start_cmd(11'h600, 1'b1);
    send_byte(8'h5A);
    cs_up(1'b0);
    wait_prog(0, "unaligned R4");
    chk(amem[11'h600] == 8'hEE, "R4 unaligned no write", amem[11'h600], 8'hEE);
    start_cmd(11'h610, 1'b1);
    cs_up(1'b1);
    wait_prog(0, "empty R4");
    start_cmd(11'h640, 1'b0);
    send_byte(8'h77);
    cs_up(1'b1);
    wait_prog(0, "no-wel R5");
    chk(amem[11'h640] == 8'hEE, "R5 discarded", amem[11'h640], 8'hEE);
  endtask

  task automatic t_protect();
    prot_lo = 12'h508;
    start_cmd(11'h504, 1'b1);
    for (int k = 0; k < 8; k++) send_byte(8'(8'hA0 + k));
    cs_up(1'b1);
    wait_prog(TWC, "protect");
    chk(amem[11'h507] == 8'hA3, "R7 open byte written", amem[11'h507], 8'hA3);
    chk(amem[11'h508] == 8'hEE, "R7 protected skipped", amem[11'h508], 8'hEE);
    chk(amem[11'h50B] == 8'hEE, "R7 protected skipped hi", amem[11'h50B], 8'hEE);
    prot_lo = 12'h800;
  endtask

  task automatic t_busy_ignore();
    int n = 0;
    start_cmd(11'h700, 1'b1);
    send_byte(8'h11);
    cs_up(1'b1);
    // inject a full foreign command inside the busy window
    wr_start = 1'b1; wr_addr = 11'h740; wel = 1'b1; n++; @(negedge clk);
    wr_start = 1'b0; byte_vld = 1'b1; byte_d = 8'h22; n++; @(negedge clk);
    byte_vld = 1'b0; cs_rise = 1'b1; aligned = 1'b1; n++; @(negedge clk);
    cs_rise = 1'b0; aligned = 1'b0;
    while (busy && n < TWC + 20) begin n++; @(negedge clk); end
    chk(n == TWC, "R10 busy length unchanged", n, TWC);
    chk(wel_clr, "R9 pulse after ignored traffic", wel_clr, 1);
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk(!busy, "R10 no second programming", busy, 0);
    chk(amem[11'h740] == 8'hEE, "R10 foreign data dropped", amem[11'h740], 8'hEE);
    chk(amem[11'h700] == 8'h11, "R10 running write done", amem[11'h700], 8'h11);
  endtask

  task automatic t_walk_window();
    int we_late = 0;
    start_cmd(11'h43F, 1'b1);
    send_byte(8'h99);
    cs_up(1'b1);
    for (int k = 1; k < TWC; k++) begin
      if (arr_we && k > 64) we_late++;
      if (arr_we) chk(k == 64, "R11 offset 63 written in cycle 64", k, 64);
      @(negedge clk);
    end
    chk(we_late == 0, "R11 no late writes", we_late, 0);
    @(negedge clk);
    chk(amem[11'h43F] == 8'h99, "R11 walk committed", amem[11'h43F], 8'h99);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) amem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_overwrite();
    t_aborts();
    t_protect();
    t_busy_ignore();
    t_walk_window();
    report();
  end
endmodule